// File: doc/BRIEF.md
# Serial EEPROM Word Address Pointer

This block holds the internal byte pointer of a serial EEPROM with 2K bytes. The pointer has 11 bits. Its top 3 bits select one of eight 256-byte blocks, and its low 8 bits select a byte within that block. The pointer is loaded from the block-select bits taken from the device address byte together with the word address byte that follows it. It advances by one after each data byte that moves over the bus. Between transactions it keeps its value, so a read that sends no word address starts at the byte after the last one accessed.

The wrap rule depends on the direction of the transfer. A write increment changes only the low 4 bits, so a burst that runs past the end of a 16-byte page returns to the first byte of the same page and overwrites earlier data. A read increment advances the whole 11-bit value, so sequential reads cross page and block boundaries and wrap from the last byte of the array back to byte zero. For a random read, the dummy write phase loads the pointer before the read begins.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: One cycle after a clock edge that samples `loadPtr` high, `ptrAddr` equals `{loadBlock, loadWord}`, with `loadBlock` in bits 10:8 and `loadWord` in bits 7:0.
- R2: A write increment (`incWrite` high, `loadPtr` low) sets bits 3:0 to their previous value plus one, modulo 16. Bits 10:4 do not change, so xxx_xxxx_1111 becomes xxx_xxxx_0000.
- R3: A read increment (`incRead` high, `incWrite` and `loadPtr` low) adds one to the full 11-bit value. The carry crosses page and block boundaries, and 0x7FF becomes 0x000.
- R4: When `loadPtr`, `incWrite` and `incRead` are all low, `ptrAddr` keeps its value for any number of cycles.
- R5: When `loadPtr` is high in the same cycle as either increment, the load applies and the increment is ignored.
- R6: When `incWrite` and `incRead` are both high and `loadPtr` is low, the write rule of R2 applies.
- R7: While `rstN` is low, `ptrAddr` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| loadPtr | input | 1 | Load the pointer from the block and word inputs |
| loadBlock | input | 3 | Block-select bits from the device address byte |
| loadWord | input | 8 | Word address byte |
| incWrite | input | 1 | A data byte was written; advance with page wrap |
| incRead | input | 1 | A data byte was read; advance with array wrap |
| ptrAddr | output | 11 | Current pointer value |

## Verification
Assertions check four rules on every cycle. A load lands as the concatenated value. A write step changes only the page-local bits and preserves the page bits. A read step adds one across all 11 bits. An idle cycle leaves the pointer unchanged. The control assertions also confirm that a load suppresses both increment strobes and that the write strobe wins over the read strobe. Only the bench scenarios can show certain end-to-end results: a 16-byte write burst returning to its starting byte, the wrap from 0x7FF to 0x000 and the carry from one block into the next, and the value reached after reset.

// File: rtl/eeprom_addr_ptr_pkg.sv
package eeprom_addr_ptr_pkg;

  // Strobes from the control decoder to the pointer datapath.
  // At most one of them is set in any cycle.
  typedef struct packed {
    logic doLoad;
    logic doPageInc;
    logic doArrayInc;
  } ptrStrobes_t;

endpackage

// File: rtl/eeprom_addr_ptr_ctrl.sv
module eeprom_addr_ptr_ctrl
  import eeprom_addr_ptr_pkg::*;
(
  input  logic        loadPtr,
  input  logic        incWrite,
  input  logic        incRead,
  output ptrStrobes_t strb
);

  // Priority: load first, then the write step, then the read step.
  always_comb begin
    strb            = '0;
    strb.doLoad     = loadPtr;
    strb.doPageInc  = !loadPtr && incWrite;
    strb.doArrayInc = !loadPtr && !incWrite && incRead;
  end

  always_comb begin
    if (loadPtr) begin
      assert_load_priority_R5: assert (strb.doLoad && !strb.doPageInc && !strb.doArrayInc);
    end
    if (!loadPtr && incWrite) begin
      assert_write_over_read_R6: assert (strb.doPageInc && !strb.doArrayInc);
    end
  end

endmodule

// File: rtl/eeprom_addr_ptr_dp.sv
module eeprom_addr_ptr_dp
  import eeprom_addr_ptr_pkg::*;
#(
  parameter int BLOCK_BITS = 3,
  parameter int WORD_BITS  = 8,
  parameter int PAGE_BITS  = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ptrStrobes_t                      strb,
  input  logic [BLOCK_BITS-1:0]            loadBlock,
  input  logic [WORD_BITS-1:0]             loadWord,
  output logic [BLOCK_BITS+WORD_BITS-1:0]  ptrAddr
);

  localparam int ADDR_W = BLOCK_BITS + WORD_BITS;
  localparam int ROW_W  = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]    ptrQ;
  logic [ADDR_W-1:0]    ptrD;
  logic [PAGE_BITS-1:0] pageLow;
  logic [ROW_W-1:0]     pageRow;
  logic [ADDR_W-1:0]    pageStep;
  logic [ADDR_W-1:0]    arrayStep;

  assign pageLow   = ptrQ[PAGE_BITS-1:0];
  assign pageRow   = ptrQ[ADDR_W-1:PAGE_BITS];
  // The write step keeps the page row and wraps the low bits.
  assign pageStep  = {pageRow, pageLow + PAGE_BITS'(1)};
  // The read step carries through all bits.
  assign arrayStep = ptrQ + ADDR_W'(1);

  always_comb begin
    ptrD = ptrQ;
    if (strb.doLoad)          ptrD = {loadBlock, loadWord};
    else if (strb.doPageInc)  ptrD = pageStep;
    else if (strb.doArrayInc) ptrD = arrayStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else       ptrQ <= ptrD;
  end

  assign ptrAddr = ptrQ;

  assert_load_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLoad |=> ptrAddr == {$past(loadBlock), $past(loadWord)});

  assert_page_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPageInc |=> (ptrAddr[ADDR_W-1:PAGE_BITS] == $past(ptrAddr[ADDR_W-1:PAGE_BITS]))
                    && (ptrAddr[PAGE_BITS-1:0] == $past(ptrAddr[PAGE_BITS-1:0]) + PAGE_BITS'(1)));

  assert_array_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doArrayInc |=> ptrAddr == $past(ptrAddr) + ADDR_W'(1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(ptrAddr));

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr
  import eeprom_addr_ptr_pkg::*;
#(
  parameter int BLOCK_BITS = 3,
  parameter int WORD_BITS  = 8,
  parameter int PAGE_BITS  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            loadPtr,
  input  logic [BLOCK_BITS-1:0]           loadBlock,
  input  logic [WORD_BITS-1:0]            loadWord,
  input  logic                            incWrite,
  input  logic                            incRead,
  output logic [BLOCK_BITS+WORD_BITS-1:0] ptrAddr
);

  ptrStrobes_t strb;

  eeprom_addr_ptr_ctrl ctrl_i (
    .loadPtr  (loadPtr),
    .incWrite (incWrite),
    .incRead  (incRead),
    .strb     (strb)
  );

  eeprom_addr_ptr_dp #(
    .BLOCK_BITS (BLOCK_BITS),
    .WORD_BITS  (WORD_BITS),
    .PAGE_BITS  (PAGE_BITS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadBlock (loadBlock),
    .loadWord  (loadWord),
    .ptrAddr   (ptrAddr)
  );

endmodule

// File: tb/eeprom_addr_ptr_tb_top.sv
module eeprom_addr_ptr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 19;

  typedef struct packed {
    logic        ld;
    logic [2:0]  blk;
    logic [7:0]  word;
    logic        iw;
    logic        ir;
    logic [10:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Rows run in order; each expected value is the pointer one cycle later.
  localparam vec_t VEC [N_VEC] = '{
    '{1'b1, 3'd5, 8'h3E, 1'b0, 1'b0, 11'h53E, 4'd1}, // R1 load
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 11'h53F, 4'd2}, // R2 write step
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 11'h530, 4'd2}, // R2 page wrap
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 11'h531, 4'd2},
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h532, 4'd3}, // R3 read step
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 11'h532, 4'd4}, // R4 hold
    '{1'b1, 3'd7, 8'hFE, 1'b0, 1'b0, 11'h7FE, 4'd1},
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h7FF, 4'd3},
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h000, 4'd3}, // R3 array wrap
    '{1'b1, 3'd7, 8'hFF, 1'b0, 1'b1, 11'h7FF, 4'd5}, // R5 load beats read
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 11'h7F0, 4'd2}, // R2 wrap in top page
    '{1'b1, 3'd2, 8'h0F, 1'b1, 1'b0, 11'h20F, 4'd5}, // R5 load beats write
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 11'h200, 4'd6}, // R6 write rule wins
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h201, 4'd3},
    '{1'b1, 3'd0, 8'h8F, 1'b0, 1'b0, 11'h08F, 4'd1},
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h090, 4'd3}, // R3 carry into next page
    '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 11'h091, 4'd2},
    '{1'b1, 3'd0, 8'hFF, 1'b0, 1'b0, 11'h0FF, 4'd1},
    '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 11'h100, 4'd3}  // R3 carry into next block
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadPtr = 1'b0;
  logic [2:0]  loadBlock = '0;
  logic [7:0]  loadWord = '0;
  logic        incWrite = 1'b0;
  logic        incRead = 1'b0;
  logic [10:0] ptrAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_addr_ptr dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .loadPtr   (loadPtr),
    .loadBlock (loadBlock),
    .loadWord  (loadWord),
    .incWrite  (incWrite),
    .incRead   (incRead),
    .ptrAddr   (ptrAddr)
  );

  task automatic check(input string req, input logic [10:0] expVal);
    checks++;
    if (ptrAddr !== expVal) begin
      errors++;
      $display("FAIL %s: ptrAddr=%h expected=%h", req, ptrAddr, expVal);
    end
  endtask

  // Called at a falling edge: drive, then check at the next falling edge.
  task automatic drive(input logic ld, input logic [2:0] blk, input logic [7:0] wd,
                       input logic iw, input logic ir);
    loadPtr = ld; loadBlock = blk; loadWord = wd; incWrite = iw; incRead = ir;
    @(negedge clk);
    loadPtr = 1'b0; incWrite = 1'b0; incRead = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", 11'h000);                 // R7 reset value
    drive(1'b1, 3'd4, 8'h55, 1'b0, 1'b0); // pointer stays zero during reset
    check("R7", 11'h000);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", 11'h000);

    for (int i = 0; i < N_VEC; i++) begin
      drive(VEC[i].ld, VEC[i].blk, VEC[i].word, VEC[i].iw, VEC[i].ir);
      check($sformatf("R%0d", VEC[i].req), VEC[i].exp);
    end

    // R2: a write burst of 16 bytes returns to its starting byte
    drive(1'b1, 3'd3, 8'hA5, 1'b0, 1'b0);
    check("R1", 11'h3A5);
    for (int k = 1; k <= 16; k++) begin
      drive(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
      check("R2", {7'h3A, 4'((5 + k) % 16)});
    end

    // R4: a long idle period keeps the value
    repeat (20) @(negedge clk);
    check("R4", 11'h3A5);

    // R3: read burst across the whole top end of the array
    drive(1'b1, 3'd7, 8'hF8, 1'b0, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
      check("R3", 11'((11'h7F8 + k) % 2048));
    end

    // R7: reset in the middle of operation clears the pointer
    rstN = 1'b0;
    @(negedge clk);
    check("R7", 11'h000);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", 11'h000);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule